// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator Unit

This unit watches the word address of every fetched instruction and tests it against four programmable comparators. Each comparator works out only two raw relations between the fetch address and its reference, equality and less-than, and derives the selected event (equal, not-equal, greater-than or less-than) from that pair. Greater-or-equal and less-or-equal need no extra hardware. Software asks for greater-than with the reference set one below the wanted bound, or for less-than with the reference set one above it.

Matches go out on three outputs, each one cycle after the fetch strobe. A watchpoint pin vector always reports matches. An event vector feeds the debug counters and is held back while the CPU is not recoverable in masked mode. A single breakpoint request goes to the debug controller. The unit starts in masked mode, where breakpoints are dropped while the recoverable input is low. A control bit selects non-masked mode, in which breakpoints are always taken.

An ignore-first-match bit supports a debugger "continue". After the breakpoint logic is newly armed, the first qualifying breakpoint is swallowed and the hardware clears the bit. The logic is armed by the first write to the control register after reset, or in masked mode by a rising recoverable input. Configuration arrives through a one-cycle write port.

Top module: `ia_bkpt_unit`

## Requirements
- R1: After reset all outputs are low, every comparator is disabled with reference 0, the unit is in masked mode and ignore-first-match is clear.
- R2: A comparator of kind 0 (equal) hits when fetch_addr[31:2] equals its reference.
- R3: A comparator of kind 1 (not-equal) hits when fetch_addr[31:2] differs from its reference.
- R4: With the signed flag clear, kind 2 (greater-than) and kind 3 (less-than) compare the 30-bit word addresses as unsigned numbers, strictly.
- R5: With the signed flag set, the less-than and greater-than relations treat bit 29 of the word address (fetch_addr[31]) as a two's-complement sign.
- R6: A disabled comparator, or a cycle with fetch_valid low, produces no pin, event or breakpoint output.
- R7: Outputs reflect the fetch of the previous cycle. A configuration write changes behaviour from the next cycle onwards, and a fetch in the same cycle as the write uses the old setting.
- R8: wp_pin_o shows every comparator hit, whatever the recoverable input and the mode.
- R9: In masked mode with recoverable low, hits do not reach evt_o and no breakpoint is requested.
- R10: In non-masked mode (control bit 17) hits reach evt_o and raise bkpt_o whatever the recoverable input.
- R11: With ignore-first-match (control bit 16) set, the first qualifying hit after arming raises no breakpoint and clears the bit. Later hits do raise one. The first control write after reset arms the logic.
- R12: In masked mode, a low-to-high change of the recoverable input also arms the logic.
- R13: With ignore-first-match clear, every qualifying hit raises bkpt_o.
- R14: Write port encoding: cfg_sel 0..3 loads the reference of comparator 0..3 from cfg_wdata[31:2]. cfg_sel 4 writes the control register. Nibble i of the control register holds comparator i's setting: bits 1:0 kind, bit 2 signed, bit 3 enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Qualifies fetch_addr in this cycle |
| fetch_addr | input | 32 | Byte address of the fetched instruction |
| recov | input | 1 | CPU recoverable-interrupt status |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (0..3 reference, 4 control) |
| cfg_wdata | input | 32 | Write data |
| evt_o | output | 4 | Per-comparator event to the debug counters |
| wp_pin_o | output | 4 | Per-comparator watchpoint pins |
| bkpt_o | output | 1 | Instruction breakpoint request |

## Verification
The assertions assume that a control write never falls in the same cycle as a rising recoverable input, and that non-masked mode is not switched in the cycle where arming is decided, so that the arm and consume ordering is unambiguous. The stimulus changes recov and the control register only in cycles apart from each other. It issues one deliberate write-plus-fetch collision to probe R7. The reference model in the bench follows the same precedence and is compared on every clock.

// File: rtl/ia_bkpt_pkg.sv
package ia_bkpt_pkg;

    typedef enum logic [1:0] {
        K_EQ = 2'd0,
        K_NE = 2'd1,
        K_GT = 2'd2,
        K_LT = 2'd3
    } cmp_kind_e;

    // layout matches one control-register nibble: {en, sgn, kind}
    typedef struct packed {
        logic      en;
        logic      sgn;
        cmp_kind_e kind;
    } cmp_cfg_t;

    localparam int CFG_W = $bits(cmp_cfg_t);

endpackage

// File: rtl/ia_cmp_slice.sv
module ia_cmp_slice
    import ia_bkpt_pkg::*;
#(
    parameter int CW = 30
) (
    input  logic [CW-1:0] addr_w,
    input  logic [CW-1:0] ref_w,
    input  cmp_cfg_t      cfg,
    output logic          hit
);

    logic          eq_raw;
    logic          lt_raw;
    logic [CW-1:0] a_key;
    logic [CW-1:0] r_key;

    // signed order becomes unsigned order once the sign bit is inverted
    always_comb begin
        a_key  = addr_w;
        r_key  = ref_w;
        if (cfg.sgn) begin
            a_key[CW-1] = ~addr_w[CW-1];
            r_key[CW-1] = ~ref_w[CW-1];
        end
        eq_raw = (addr_w == ref_w);
        lt_raw = (a_key < r_key);
    end

    always_comb begin
        hit = 1'b0;
        if (cfg.en) begin
            unique case (cfg.kind)
                K_EQ: hit = eq_raw;
                K_NE: hit = ~eq_raw;
                K_GT: hit = ~eq_raw & ~lt_raw;
                K_LT: hit = lt_raw;
                default: hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ia_bkpt_regs.sv
module ia_bkpt_regs
    import ia_bkpt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int ADDR_W  = 32,
    parameter int SEL_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [SEL_W-1:0]                 cfg_sel,
    input  logic [ADDR_W-1:0]                cfg_wdata,
    output logic [NUM_CMP-1:0][ADDR_W-3:0]   refs_o,
    output cmp_cfg_t [NUM_CMP-1:0]           cfgs_o,
    output logic                             nomask_o,
    output logic                             ctrl_wr_o,
    output logic                             ifm_wr_o
);

    localparam int CW         = ADDR_W - 2;
    localparam int IFM_BIT    = NUM_CMP * CFG_W;
    localparam int NOMASK_BIT = IFM_BIT + 1;

    typedef struct packed {
        logic [NUM_CMP-1:0][CW-1:0] refs;
        cmp_cfg_t [NUM_CMP-1:0]     cfgs;
        logic                       nomask;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    ctrl_hit;

    always_comb begin
        st_d     = st_q;
        ctrl_hit = cfg_we && (cfg_sel == SEL_W'(NUM_CMP));
        for (int i = 0; i < NUM_CMP; i++) begin
            if (cfg_we && (cfg_sel == SEL_W'(i))) begin
                st_d.refs[i] = cfg_wdata[ADDR_W-1:2];
            end
            if (ctrl_hit) begin
                st_d.cfgs[i] = cmp_cfg_t'(cfg_wdata[i*CFG_W +: CFG_W]);
            end
        end
        if (ctrl_hit) begin
            st_d.nomask = cfg_wdata[NOMASK_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign refs_o    = st_q.refs;
    assign cfgs_o    = st_q.cfgs;
    assign nomask_o  = st_q.nomask;
    assign ctrl_wr_o = ctrl_hit;
    assign ifm_wr_o  = cfg_wdata[IFM_BIT];

    // R14: a control write lands in the enable field of every comparator
    a_r14_ctrl_loads_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> (cfgs_o[0].en == $past(cfg_wdata[CFG_W-1])));

endmodule

// File: rtl/ia_bkpt_ctrl.sv
module ia_bkpt_ctrl #(
    parameter int NUM_CMP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic               recov,
    input  logic [NUM_CMP-1:0] hits,
    input  logic               nomask,
    input  logic               ctrl_wr,
    input  logic               ifm_wr,
    output logic [NUM_CMP-1:0] evt_o,
    output logic [NUM_CMP-1:0] wp_pin_o,
    output logic               bkpt_o
);

    typedef struct packed {
        logic               ifm;
        logic               wrote;
        logic               fresh;
        logic               recov_prev;
        logic [NUM_CMP-1:0] evt;
        logic [NUM_CMP-1:0] pin;
        logic               bkpt;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    qual;
    logic    cand;
    logic    ignore;
    logic    arm;

    always_comb begin
        st_d   = st_q;
        qual   = nomask || recov;
        cand   = fetch_valid && (|hits) && qual;
        ignore = cand && st_q.fresh && st_q.ifm;
        arm    = (ctrl_wr && !st_q.wrote) ||
                 (!nomask && recov && !st_q.recov_prev);

        st_d.pin        = fetch_valid ? hits : '0;
        st_d.evt        = (fetch_valid && qual) ? hits : '0;
        st_d.bkpt       = cand && !ignore;
        st_d.recov_prev = recov;
        st_d.wrote      = st_q.wrote || ctrl_wr;

        if (ctrl_wr) begin
            st_d.ifm = ifm_wr;
        end else if (ignore) begin
            st_d.ifm = 1'b0;
        end

        if (arm) begin
            st_d.fresh = 1'b1;
        end else if (cand) begin
            st_d.fresh = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o    = st_q.evt;
    assign wp_pin_o = st_q.pin;
    assign bkpt_o   = st_q.bkpt;

    // R6: no strobe, nothing reported in the following cycle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (wp_pin_o == '0 && evt_o == '0 && !bkpt_o));

    // R9: masked mode and not recoverable means no counter event, no breakpoint
    a_r9_masked_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !nomask && !recov) |=> (evt_o == '0 && !bkpt_o));

    // R8: every counted event is also visible on the pins
    a_r8_evt_within_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o & ~wp_pin_o) == '0);

    // R11: an ignored match clears the bit and raises no request
    a_r11_ifm_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ignore && !ctrl_wr) |=> (!st_q.ifm && !bkpt_o));

    // R10: non-masked mode takes every hit unless it is the one ignored
    a_r10_nomask_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && nomask && (|hits) && !(st_q.fresh && st_q.ifm)) |=> bkpt_o);

    // R13: breakpoint request implies a pin is active
    a_r13_bkpt_has_pin: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_o |-> (wp_pin_o != '0));

endmodule

// File: rtl/ia_bkpt_unit.sv
module ia_bkpt_unit
    import ia_bkpt_pkg::*;
#(
    parameter  int NUM_CMP = 4,
    parameter  int ADDR_W  = 32,
    localparam int SEL_W   = $clog2(NUM_CMP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [ADDR_W-1:0]  fetch_addr,
    input  logic               recov,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    output logic [NUM_CMP-1:0] evt_o,
    output logic [NUM_CMP-1:0] wp_pin_o,
    output logic               bkpt_o
);

    localparam int CW = ADDR_W - 2;

    logic [NUM_CMP-1:0][CW-1:0] refs;
    cmp_cfg_t [NUM_CMP-1:0]     cfgs;
    logic                       nomask;
    logic                       ctrl_wr;
    logic                       ifm_wr;
    logic [NUM_CMP-1:0]         hits;

    ia_bkpt_regs #(
        .NUM_CMP (NUM_CMP),
        .ADDR_W  (ADDR_W),
        .SEL_W   (SEL_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .refs_o    (refs),
        .cfgs_o    (cfgs),
        .nomask_o  (nomask),
        .ctrl_wr_o (ctrl_wr),
        .ifm_wr_o  (ifm_wr)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        ia_cmp_slice #(
            .CW (CW)
        ) slice_i (
            .addr_w (fetch_addr[ADDR_W-1:2]),
            .ref_w  (refs[g]),
            .cfg    (cfgs[g]),
            .hit    (hits[g])
        );
    end

    ia_bkpt_ctrl #(
        .NUM_CMP (NUM_CMP)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .recov       (recov),
        .hits        (hits),
        .nomask      (nomask),
        .ctrl_wr     (ctrl_wr),
        .ifm_wr      (ifm_wr),
        .evt_o       (evt_o),
        .wp_pin_o    (wp_pin_o),
        .bkpt_o      (bkpt_o)
    );

    // R2: equal kind on comparator 0 shows up as its pin one cycle later
    a_r2_eq_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && cfgs[0].en && cfgs[0].kind == K_EQ &&
         fetch_addr[ADDR_W-1:2] == refs[0]) |=> wp_pin_o[0]);

    // R6: a disabled comparator never drives its pin
    a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cfgs[0].en |=> !wp_pin_o[0]);

endmodule

// File: tb/ia_bkpt_unit_tb_top.sv
module ia_bkpt_unit_tb_top;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        recov = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [N-1:0] evt_o, wp_pin_o;
    logic        bkpt_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ia_bkpt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .recov(recov), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .evt_o(evt_o), .wp_pin_o(wp_pin_o), .bkpt_o(bkpt_o)
    );

    // ---------------- behavioural reference model ----------------
    logic [29:0] m_ref [N];
    logic [3:0]  m_cfg [N];
    bit m_nomask, m_ifm, m_wrote, m_fresh, m_rprev;
    logic [N-1:0] e_pin, e_evt;
    bit e_bk;
    bit live = 0;

    function automatic bit m_hit(logic [31:0] a, logic [29:0] r, logic [3:0] c);
        longint av, rv;
        logic [29:0] w;
        w = a[31:2];
        if (!c[3]) return 0;
        if (c[2]) begin
            av = w[29] ? longint'(w) - (longint'(1) << 30) : longint'(w);
            rv = r[29] ? longint'(r) - (longint'(1) << 30) : longint'(r);
        end else begin
            av = longint'(w);
            rv = longint'(r);
        end
        case (c[1:0])
            2'd0: return av == rv;
            2'd1: return av != rv;
            2'd2: return av > rv;
            default: return av < rv;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_ref[i] = '0; m_cfg[i] = '0; end
            m_nomask = 0; m_ifm = 0; m_wrote = 0; m_fresh = 0; m_rprev = 0;
            e_pin = '0; e_evt = '0; e_bk = 0;
        end else begin
            logic [N-1:0] h;
            bit ok, take, skip, cw;
            for (int i = 0; i < N; i++) h[i] = fetch_valid && m_hit(fetch_addr, m_ref[i], m_cfg[i]);
            ok   = m_nomask || recov;
            take = (h != '0) && ok;
            skip = take && m_fresh && m_ifm;
            e_pin = h;
            e_evt = ok ? h : '0;
            e_bk  = take && !skip;
            cw = cfg_we && cfg_sel == 3'd4;
            if ((cw && !m_wrote) || (!m_nomask && recov && !m_rprev)) m_fresh = 1;
            else if (take) m_fresh = 0;
            if (cw) m_ifm = cfg_wdata[16];
            else if (skip) m_ifm = 0;
            m_wrote = m_wrote || cw;
            m_rprev = recov;
            if (cfg_we && cfg_sel < 3'd4) m_ref[cfg_sel] = cfg_wdata[31:2];
            if (cw) begin
                for (int i = 0; i < N; i++) m_cfg[i] = cfg_wdata[i*4 +: 4];
                m_nomask = cfg_wdata[17];
            end
        end
        live = 1;
    end

    always @(negedge clk) begin
        if (live && !done) begin
            checks++;
            if (wp_pin_o !== e_pin || evt_o !== e_evt || bkpt_o !== e_bk) begin
                errors++;
                $display("FAIL R7 model cycle t=%0t: pin/evt/bk act %h/%h/%b exp %h/%h/%b",
                         $time, wp_pin_o, evt_o, bkpt_o, e_pin, e_evt, e_bk);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(string tag, logic [N-1:0] p, logic [N-1:0] e, bit b);
        checks++;
        if (wp_pin_o !== p || evt_o !== e || bkpt_o !== b) begin
            errors++;
            $display("FAIL %s: pin/evt/bk act %h/%h/%b exp %h/%h/%b",
                     tag, wp_pin_o, evt_o, bkpt_o, p, e, b);
        end
    endtask

    task automatic wr(logic [2:0] s, logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic fetch(logic [31:0] a);
        @(negedge clk); fetch_valid = 1; fetch_addr = a;
        @(negedge clk); fetch_valid = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 4'h0, 4'h0, 0);
        rst_n = 1;
        fetch(32'h0);
        chk("R1 all disabled after reset", 4'h0, 4'h0, 0);

        wr(3'd0, 32'h0000_1000);
        wr(3'd1, 32'h0000_2000);
        wr(3'd2, 32'hF000_0000);
        wr(3'd4, 32'h0002_1EB8);      // R14 layout, non-masked
        fetch(32'h0000_1000);
        chk("R2 R4 R5 equal/less/signed-greater", 4'h7, 4'h7, 1);
        fetch(32'h0000_1004);
        chk("R2 R4 no longer equal", 4'h6, 4'h6, 1);
        fetch(32'h0000_1FFC);
        chk("R4 just below unsigned bound", 4'h6, 4'h6, 1);
        fetch(32'h0000_2000);
        chk("R4 less-than is strict", 4'h4, 4'h4, 1);
        fetch(32'h8000_0000);
        chk("R5 most negative not greater", 4'h0, 4'h0, 0);
        idle();
        chk("R6 no strobe", 4'h0, 4'h0, 0);

        wr(3'd4, 32'h0002_9EB8);      // enable D not-equal, ref 0
        fetch(32'h0000_1000);
        chk("R3 not-equal hits", 4'hF, 4'hF, 1);

        @(negedge clk);
        cfg_we = 1; cfg_sel = 3'd4; cfg_wdata = 32'h0002_0000;
        fetch_valid = 1; fetch_addr = 32'h0000_1000;
        @(negedge clk); cfg_we = 0; fetch_valid = 0;
        chk("R7 write-cycle fetch uses old config", 4'hF, 4'hF, 1);
        fetch(32'h0000_1000);
        chk("R7 R6 new config disables all", 4'h0, 4'h0, 0);

        wr(3'd4, 32'h0000_0008);      // masked mode, A equal
        recov = 0; idle();
        fetch(32'h0000_1000);
        chk("R8 R9 masked not recoverable", 4'h1, 4'h0, 0);
        recov = 1; idle();
        fetch(32'h0000_1000);
        chk("R13 taken with ignore clear", 4'h1, 4'h1, 1);
        fetch(32'h0000_1000);
        chk("R13 every match taken", 4'h1, 4'h1, 1);

        recov = 0; idle();
        wr(3'd4, 32'h0001_0008);      // ignore-first-match, masked
        idle();
        recov = 1; idle();
        fetch(32'h0000_1000);
        chk("R12 R11 rise arms, first match ignored", 4'h1, 4'h1, 0);
        fetch(32'h0000_1000);
        chk("R11 bit cleared, second taken", 4'h1, 4'h1, 1);

        @(negedge clk); rst_n = 0; recov = 0;
        @(negedge clk);
        chk("R1 reset again", 4'h0, 4'h0, 0);
        rst_n = 1; idle();
        wr(3'd4, 32'h0003_0008);      // first write: ignore + non-masked
        fetch(32'h0000_0000);
        chk("R11 R10 first write arms, ignored", 4'h1, 4'h1, 0);
        fetch(32'h0000_0000);
        chk("R10 taken while not recoverable", 4'h1, 4'h1, 1);
        idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: act hung exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule